// File: doc/BRIEF.md
# Timer with Comparator Edge Capture

A 16-bit up-counting timer that can time-stamp the rising edges of an asynchronous comparator output. When capture is enabled and split operation is off, every rising edge of the comparator input copies the running count into the 16-bit reload register pair and sets the high-byte timer flag. Software reads the two captured bytes after each interrupt and subtracts successive values to get the input period in timer ticks. The timer clock should be much faster than the measured signal.

The count rate is picked from the system clock, the system clock divided by 12, or an external clock divided by 8. The two divided rates are single-cycle enable pulses in the system-clock domain. When capture is not active, the timer behaves as a plain 16-bit auto-reload counter. A byte-wide register port gives software access to the count, the reload value and the flag and interrupt-enable bits.

Top module: `edge_capture_timer`

## Requirements
- R1: The count rate follows `clk_sel`. Code 0 or 3 advances the count on every system clock. Code 1 advances it once per 12 system clocks. Code 2 advances it once per 8 rising edges of `ext_clk`.
- R2: Capture mode is active only while `cap_en` is 1 and `split_en` is 0. Outside capture mode, comparator edges change neither the reload registers nor the flag.
- R3: `cmp_in` passes through a two-stage synchronizer. Each rising edge gives exactly one capture, and the capture is taken on the third system clock edge after the input rises. An input that stays high gives no further captures.
- R4: A capture copies the full 16-bit count into the reload registers (low byte at address 2, high byte at address 3). If software writes the reload registers in the same cycle, the captured value wins.
- R5: A capture sets the flag (bit 7 at address 4). The flag stays set until software writes 0 to it. `irq` is 1 exactly when the flag and the interrupt enable (bit 0 at address 4) are both 1.
- R6: The count changes only while `run_en` is 1, apart from software writes to the count bytes (low at address 0, high at address 1).
- R7: In capture mode the count wraps from 0xFFFF to 0x0000 without reloading, and the wrap sets the flag.
- R8: Outside capture mode, a count at 0xFFFF that advances is loaded from the reload registers, and the flag is set.
- R9: With a running count, the difference between two successive captured values equals the number of ticks between the two comparator rising edges.
- R10: After reset the count, the reload value, the flag, the interrupt enable and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Count rate select (0/3 system, 1 system/12, 2 external/8) |
| ext_clk | input | 1 | Asynchronous external clock |
| run_en | input | 1 | Counter run enable |
| cap_en | input | 1 | Capture enable |
| split_en | input | 1 | Split operation; blocks capture when 1 |
| cmp_in | input | 1 | Asynchronous comparator output |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count, prescale ratios of 12 and 8, and two synchronizer stages. With these values the wrap and reload boundaries at 0xFFFF, the exact three-clock capture latency and the exact tick counts of every rate can all be reached in a few hundred cycles. The external clock runs at one tenth of the system clock, so a 640-cycle window holds exactly eight divided ticks. The bench also lines up a software reload write with the capture cycle to check which one wins.

// File: rtl/ect_pkg.sv
package ect_pkg;
  typedef enum logic [1:0] {
    SRC_SYS     = 2'd0,
    SRC_DIV_A   = 2'd1,
    SRC_EXT     = 2'd2,
    SRC_SYS_ALT = 2'd3
  } clk_src_e;

  localparam logic [2:0] ADDR_CNT_LO = 3'd0;
  localparam logic [2:0] ADDR_CNT_HI = 3'd1;
  localparam logic [2:0] ADDR_RLD_LO = 3'd2;
  localparam logic [2:0] ADDR_RLD_HI = 3'd3;
  localparam logic [2:0] ADDR_FLAGS  = 3'd4;
endpackage

// File: rtl/ect_edge_sync.sv
module ect_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3
endmodule

// File: rtl/ect_prescale.sv
module ect_prescale
  import ect_pkg::*;
#(
  parameter int DIV_A       = 12,
  parameter int DIV_B       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ext_clk,
  input  clk_src_e sel,
  output logic     tick
);
  localparam int AW = (DIV_A > 1) ? $clog2(DIV_A) : 1;
  localparam int BW = (DIV_B > 1) ? $clog2(DIV_B) : 1;
  localparam logic [AW-1:0] A_LAST = AW'(DIV_A - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DIV_B - 1);

  logic          ext_rise;
  logic [AW-1:0] a_q, a_d;
  logic [BW-1:0] b_q, b_d;
  logic          a_tick, b_tick;

  ect_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_clk),
    .rise     (ext_rise)
  );

  always_comb begin
    a_tick = (a_q == A_LAST);
    a_d    = a_tick ? '0 : a_q + 1'b1;
    b_tick = ext_rise && (b_q == B_LAST);
    b_d    = b_q;
    if (ext_rise) b_d = (b_q == B_LAST) ? '0 : b_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  always_comb begin
    unique case (sel)
      SRC_DIV_A: tick = a_tick;
      SRC_EXT:   tick = b_tick;
      default:   tick = 1'b1;
    endcase
  end

  AST_DIV_A_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    a_tick |=> !a_tick); // R1
  AST_EXT_TICK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_EXT && tick) |-> ext_rise); // R1
endmodule

// File: rtl/ect_timer_core.sv
module ect_timer_core #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               cap_mode,
  input  logic               cap_evt,
  input  logic               cnt_wr_lo,
  input  logic               cnt_wr_hi,
  input  logic               rld_wr_lo,
  input  logic               rld_wr_hi,
  input  logic               flag_wr,
  input  logic               flag_wval,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   rld,
  output logic               flag
);
  localparam int BYTE_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_d, rld_d;
  logic             flag_d;
  logic             ovf, capture;

  always_comb begin
    ovf     = advance && (cnt == '1);
    capture = cap_mode && cap_evt;

    cnt_d = cnt;
    if (advance) cnt_d = ovf ? (cap_mode ? '0 : rld) : cnt + 1'b1;
    if (cnt_wr_lo) cnt_d[BYTE_W-1:0]     = wdata;
    if (cnt_wr_hi) cnt_d[CNT_W-1:BYTE_W] = wdata;

    rld_d = rld;
    if (rld_wr_lo) rld_d[BYTE_W-1:0]     = wdata;
    if (rld_wr_hi) rld_d[CNT_W-1:BYTE_W] = wdata;
    if (capture)   rld_d = cnt;

    flag_d = flag;
    if (flag_wr) flag_d = flag_wval;
    if (ovf || capture) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rld  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      rld  <= rld_d;
      flag <= flag_d;
    end
  end

  AST_CAP_LOADS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && cap_evt) |=> (rld == $past(cnt))); // R4
  AST_CAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && cap_evt) |=> flag); // R5
  AST_NO_CAP_OUTSIDE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && !rld_wr_lo && !rld_wr_hi) |=> $stable(rld)); // R2
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !cnt_wr_lo && !cnt_wr_hi) |=> $stable(cnt)); // R6
  AST_CAP_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && advance && cnt == '1 && !cnt_wr_lo && !cnt_wr_hi) |=> (cnt == '0 && flag)); // R7
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_A       = 12,
  parameter int DIV_B       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         clk_sel,
  input  logic               ext_clk,
  input  logic               run_en,
  input  logic               cap_en,
  input  logic               split_en,
  input  logic               cmp_in,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [CNT_W/2-1:0] reg_wdata,
  output logic [CNT_W/2-1:0] reg_rdata,
  output logic               irq
);
  localparam int BYTE_W = CNT_W / 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             tick, cmp_rise, cap_mode;
  logic [CNT_W-1:0] cnt, rld;
  logic             flag;
  logic             ien_q, ien_d;
  logic             wr_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ect_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .SYNC_STAGES(SYNC_STAGES)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ext_clk (ext_clk),
    .sel     (clk_src_e'(clk_sel)),
    .tick    (tick)
  );

  ect_edge_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (cmp_in),
    .rise     (cmp_rise)
  );

  assign cap_mode = cap_en && !split_en;
  assign wr_flags = reg_we && (reg_addr == ADDR_FLAGS);

  ect_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .advance   (run_en && tick),
    .cap_mode  (cap_mode),
    .cap_evt   (cmp_rise),
    .cnt_wr_lo (reg_we && reg_addr == ADDR_CNT_LO),
    .cnt_wr_hi (reg_we && reg_addr == ADDR_CNT_HI),
    .rld_wr_lo (reg_we && reg_addr == ADDR_RLD_LO),
    .rld_wr_hi (reg_we && reg_addr == ADDR_RLD_HI),
    .flag_wr   (wr_flags),
    .flag_wval (reg_wdata[BYTE_W-1]),
    .wdata     (reg_wdata),
    .cnt       (cnt),
    .rld       (rld),
    .flag      (flag)
  );

  always_comb begin
    ien_d = wr_flags ? reg_wdata[0] : ien_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ien_q <= 1'b0;
    else            ien_q <= ien_d;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CNT_LO: reg_rdata = cnt[BYTE_W-1:0];
      ADDR_CNT_HI: reg_rdata = cnt[CNT_W-1:BYTE_W];
      ADDR_RLD_LO: reg_rdata = rld[BYTE_W-1:0];
      ADDR_RLD_HI: reg_rdata = rld[CNT_W-1:BYTE_W];
      ADDR_FLAGS: begin
        reg_rdata[BYTE_W-1] = flag;
        reg_rdata[0]        = ien_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq = flag && ien_q;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq && $stable(ien_q)) |-> $past(ien_q)); // R5
  AST_SPLIT_BLOCKS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (split_en && !reg_we) |=> $stable(rld)); // R2
endmodule

// File: tb/edge_capture_timer_tb.sv
module edge_capture_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic       ext_clk = 1'b0;
  logic       run_en = 1'b0, cap_en = 1'b0, split_en = 1'b0, cmp_in = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  edge_capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk),
    .run_en(run_en), .cap_en(cap_en), .split_en(split_en), .cmp_in(cmp_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5ns clk = ~clk;

  initial begin
    #2ns;
    forever #50ns ext_clk = ~ext_clk;
  end

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // {sel[1:0], run, cycles[11:0], expected count[15:0]}
  localparam logic [30:0] VEC [0:4] = '{
    {2'd0, 1'b1, 12'd30,  16'd30},
    {2'd1, 1'b1, 12'd120, 16'd10},
    {2'd2, 1'b1, 12'd640, 16'd8},
    {2'd3, 1'b1, 12'd7,   16'd7},
    {2'd0, 1'b0, 12'd50,  16'd0}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] base, output logic [15:0] v);
    reg_addr = base;      #1ns; v[7:0]  = reg_rdata;
    reg_addr = base + 1;  #1ns; v[15:8] = reg_rdata;
  endtask

  task automatic rd8(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; #1ns; v = reg_rdata;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(3'd0, v[7:0]);
    wr(3'd1, v[15:8]);
  endtask

  task automatic pulse_cmp();
    @(negedge clk); cmp_in = 1'b1;
    repeat (5) @(negedge clk);
    cmp_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v, a, b;
    logic [7:0]  f;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    rd16(3'd0, v); chk("R10 count", v, 16'h0000);
    rd16(3'd2, v); chk("R10 reload", v, 16'h0000);
    rd8(3'd4, f);  chk("R10 flags", {8'd0, f}, 16'h0000);
    chk("R10 irq", {15'd0, irq}, 16'd0);

    // R1 / R6 rate table
    foreach (VEC[i]) begin
      set_cnt(16'h0000);
      clk_sel = VEC[i][30:29];
      @(negedge clk);
      run_en = VEC[i][28];
      repeat (int'(VEC[i][27:16])) @(negedge clk);
      run_en = 1'b0;
      rd16(3'd0, v);
      chk($sformatf("R1 R6 rate vector %0d", i), v, VEC[i][15:0]);
    end
    clk_sel = 2'd0;

    // R4 / R5 capture copies count, sets flag
    cap_en = 1'b1;
    set_cnt(16'h1234);
    pulse_cmp();
    rd16(3'd2, v); chk("R4 capture value", v, 16'h1234);
    rd8(3'd4, f);  chk("R5 flag set by capture", {15'd0, f[7]}, 16'd1);
    chk("R5 irq masked", {15'd0, irq}, 16'd0);
    wr(3'd4, 8'h01);
    rd8(3'd4, f);  chk("R5 flag cleared by write", {8'd0, f}, 16'h0001);
    set_cnt(16'hABCD);
    pulse_cmp();
    rd16(3'd2, v); chk("R4 second capture", v, 16'hABCD);
    chk("R5 irq raised", {15'd0, irq}, 16'd1);
    repeat (10) @(negedge clk);
    chk("R5 flag sticky", {15'd0, irq}, 16'd1);
    wr(3'd4, 8'h01);
    chk("R5 irq after clear", {15'd0, irq}, 16'd0);

    // R3 held-high input captures once
    set_cnt(16'h0101);
    @(negedge clk); cmp_in = 1'b1;
    repeat (5) @(negedge clk);
    set_cnt(16'h5555);
    repeat (10) @(negedge clk);
    rd16(3'd2, v); chk("R3 single capture while high", v, 16'h0101);
    cmp_in = 1'b0;
    repeat (5) @(negedge clk);

    // R3 latency and R4 priority over same-cycle reload write
    set_cnt(16'h4242);
    @(negedge clk); cmp_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h99;
    @(negedge clk);
    reg_we = 1'b0;
    rd16(3'd2, v); chk("R3 R4 capture wins on third edge", v, 16'h4242);
    cmp_in = 1'b0;
    repeat (5) @(negedge clk);

    // R2 split or disabled capture ignores edges
    wr(3'd4, 8'h00);
    split_en = 1'b1;
    set_cnt(16'h7777);
    pulse_cmp();
    rd16(3'd2, v); chk("R2 split blocks capture", v, 16'h4242);
    rd8(3'd4, f);  chk("R2 split leaves flag", {8'd0, f}, 16'h0000);
    split_en = 1'b0; cap_en = 1'b0;
    pulse_cmp();
    rd16(3'd2, v); chk("R2 disabled blocks capture", v, 16'h4242);
    rd8(3'd4, f);  chk("R2 disabled leaves flag", {8'd0, f}, 16'h0000);

    // R7 wrap in capture mode
    cap_en = 1'b1;
    set_cnt(16'hFFFE);
    @(negedge clk); run_en = 1'b1;
    repeat (3) @(negedge clk);
    run_en = 1'b0;
    rd16(3'd0, v); chk("R7 wrap to zero", v, 16'h0001);
    rd8(3'd4, f);  chk("R7 wrap flag", {15'd0, f[7]}, 16'd1);
    rd16(3'd2, v); chk("R7 reload untouched", v, 16'h4242);

    // R8 auto-reload outside capture mode
    cap_en = 1'b0;
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hFF);
    set_cnt(16'hFFFE);
    @(negedge clk); run_en = 1'b1;
    repeat (2) @(negedge clk);
    run_en = 1'b0;
    rd16(3'd0, v); chk("R8 reload on overflow", v, 16'hFF00);
    rd8(3'd4, f);  chk("R8 overflow flag", {15'd0, f[7]}, 16'd1);

    // R9 period measurement
    cap_en = 1'b1;
    set_cnt(16'h0000);
    @(negedge clk); run_en = 1'b1;
    repeat (3) @(negedge clk);
    cmp_in = 1'b1;
    repeat (5) @(negedge clk);
    rd16(3'd2, a);
    cmp_in = 1'b0;
    repeat (32) @(negedge clk);
    cmp_in = 1'b1;
    repeat (5) @(negedge clk);
    rd16(3'd2, b);
    run_en = 1'b0;
    cmp_in = 1'b0;
    chk("R9 capture difference", b - a, 16'd37);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule